// File: doc/BRIEF.md
# Video Timing Controller Register Bank and Port Decoder

This block sits between a processor's I/O bus and the counter-and-comparator core that paces a character-based raster display. It watches each I/O cycle, decides from three address bits whether the cycle belongs to it and which of four ports it targets, and keeps the programmable values that set the frame geometry. Those values leave the block on a parallel bus and feed the timing core directly.

Writing a register takes two accesses. The first loads a 5-bit index, and the second stores the data byte into the register that the index names. The bus carries no read/write qualifier, so an access to a write port always stores whatever is on the data lines.

Read behaviour depends on a build parameter that selects one of two variants. The variants differ in which registers can be read, in the value returned for an index with no register behind it, and in whether a status byte exists. That status byte reports two things: a light-pen strobe, and whether the raster is below the displayed rows. The timing core supplies the light-pen address and the vertical-position flags as inputs.

Top module: `vidregs_top`

## Requirements
- R1: An access with address bit 14 high is ignored: no register, index or flag changes.
- R2: With bit 14 low, address bits 9 and 8 pick the port. 00 loads the index from data bits 4..0. 01 stores the data byte into the indexed register. Both ports store on any access, because no read/write qualifier exists.
- R3: Stored values are masked. Registers 4, 6 and 7 keep 7 bits. Registers 5 and 9 keep 5 bits. Registers 12 and 14 keep 6 bits. All other registers keep 8 bits.
- R4: Writes to indices 16 to 31 change nothing.
- R5: Through the read port (bits 9,8 = 11), indices 0 to 11 return 0, and indices 14 and 15 return the stored value.
- R6: Indices 12 and 13 read back their stored value in variant A and return 0 in variant B.
- R7: Index 16 returns light-pen address bits 13..8 with two zero bits on top. Index 17 returns bits 7..0.
- R8: Indices 18 to 30 read 0. Index 31 reads 0 in variant A and 0xFF in variant B.
- R9: Status bit 6 sets after a light-pen strobe and clears after a data-port read of index 16 or 17. A strobe in the same cycle wins.
- R10: Status bit 5 sets while the below-display flag is high and clears on the frame-start flag. The set wins if both are high.
- R11: The status port (bits 9,8 = 10) returns the status byte in variant B, with all bits other than 6 and 5 at 0. It returns 0 in variant A. The read output is 0 whenever no selected read access is present.
- R12: After reset all registers, the index and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStrobe | input | 1 | An I/O cycle is on the bus this clock |
| addr | input | 16 | I/O address |
| dataIn | input | 8 | Data lines from the processor |
| penStrobe | input | 1 | Light-pen strobe pulse |
| penAddr | input | 14 | Light-pen address captured by the timing core |
| vertPastDisplay | input | 1 | Vertical count has reached the displayed-rows value |
| frameStart | input | 1 | Vertical count is 0 |
| readData | output | 8 | Data returned for a read access |
| regOut | output | 16x8 | Register values 0 to 15 for the timing core |

## Verification
The read output is combinational, so it is sampled in the same cycle as the read access, one nanosecond after the inputs change. Stored registers, the index and the status bits take their new value at the next rising edge. The bench therefore checks `regOut`, and any read that depends on a write, from the following falling edge onward. A strobe or flag pulse shows in the status byte on the first access after that edge. The clearing read of index 16 or 17 takes effect at the edge that closes that access, so the bench checks for the cleared status bit on a separate, later access.

// File: rtl/vidregs_pkg.sv
package vidregs_pkg;

  typedef enum logic {
    VAR_A = 1'b0,
    VAR_B = 1'b1
  } variant_e;

  typedef struct packed {
    logic wrIndex;
    logic wrData;
    logic rdData;
    logic rdStatus;
  } busStrobe_t;

endpackage

// File: rtl/vidregs_ctrl.sv
module vidregs_ctrl
  import vidregs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEL_BIT = 14,
  parameter int DIR_BIT = 9,
  parameter int SUB_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strb
);

  logic chipSel;

  always_comb begin
    chipSel       = ioStrobe && !addr[SEL_BIT];
    strb          = '0;
    strb.wrIndex  = chipSel && !addr[DIR_BIT] && !addr[SUB_BIT];
    strb.wrData   = chipSel && !addr[DIR_BIT] &&  addr[SUB_BIT];
    strb.rdStatus = chipSel &&  addr[DIR_BIT] && !addr[SUB_BIT];
    strb.rdData   = chipSel &&  addr[DIR_BIT] &&  addr[SUB_BIT];
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIndex, strb.wrData, strb.rdData, strb.rdStatus})); // R2

endmodule

// File: rtl/vidregs_datapath.sv
module vidregs_datapath
  import vidregs_pkg::*;
#(
  parameter int       DATA_W  = 8,
  parameter int       IDX_W   = 5,
  parameter int       NUM_RW  = 16,
  parameter int       PEN_W   = 14,
  parameter variant_e VARIANT = VAR_A
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  busStrobe_t                   strb,
  input  logic [DATA_W-1:0]            dataIn,
  input  logic                         penStrobe,
  input  logic [PEN_W-1:0]             penAddr,
  input  logic                         vertPastDisplay,
  input  logic                         frameStart,
  output logic [DATA_W-1:0]            readData,
  output logic [NUM_RW-1:0][DATA_W-1:0] regOut
);

  localparam int SLOT_W  = $clog2(NUM_RW);
  localparam int PEN_BIT = 6;
  localparam int VB_BIT  = 5;
  localparam logic [IDX_W-1:0] IDX_PEN_HI = IDX_W'(16);
  localparam logic [IDX_W-1:0] IDX_PEN_LO = IDX_W'(17);
  localparam logic [IDX_W-1:0] IDX_LAST   = {IDX_W{1'b1}};

  logic [IDX_W-1:0]              idxReg;
  logic [NUM_RW-1:0][DATA_W-1:0] regs;
  logic                          penFlag;
  logic                          vbFlag;
  logic                          penClear;
  logic                          idxInFile;
  logic [DATA_W-1:0]             statusByte;
  logic [DATA_W-1:0]             rdVal;

  assign idxInFile = (idxReg < IDX_W'(NUM_RW));
  assign penClear  = strb.rdData && (idxReg == IDX_PEN_HI || idxReg == IDX_PEN_LO);

  always_ff @(posedge clk) begin
    if (!rstN)             idxReg <= '0;
    else if (strb.wrIndex) idxReg <= dataIn[IDX_W-1:0];
  end

  for (genvar gi = 0; gi < NUM_RW; gi++) begin : g_reg
    localparam int KEEP = (gi == 4 || gi == 6 || gi == 7) ? 7 :
                          (gi == 5 || gi == 9)            ? 5 :
                          (gi == 12 || gi == 14)          ? 6 : DATA_W;
    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - KEEP);
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[gi] <= '0;
      else if (strb.wrData && idxInFile && idxReg[SLOT_W-1:0] == SLOT_W'(gi))
        regs[gi] <= dataIn & MASK;
    end
  end

  if (VARIANT == VAR_B) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN) begin
        penFlag <= 1'b0;
        vbFlag  <= 1'b0;
      end else begin
        if (penStrobe)     penFlag <= 1'b1;
        else if (penClear) penFlag <= 1'b0;
        if (vertPastDisplay) vbFlag <= 1'b1;
        else if (frameStart) vbFlag <= 1'b0;
      end
    end

    AST_PEN_SET: assert property (@(posedge clk) disable iff (!rstN)
      penStrobe |=> penFlag); // R9
    AST_PEN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (penClear && !penStrobe) |=> !penFlag); // R9
    AST_VB_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (frameStart && !vertPastDisplay) |=> !vbFlag); // R10
  end else begin : g_nostatus
    assign penFlag = 1'b0;
    assign vbFlag  = 1'b0;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[PEN_BIT] = penFlag;
    statusByte[VB_BIT]  = vbFlag;
  end

  always_comb begin
    rdVal = '0;
    if (strb.rdStatus) begin
      rdVal = statusByte;
    end else if (strb.rdData) begin
      if (idxReg == IDX_W'(14) || idxReg == IDX_W'(15))
        rdVal = regs[idxReg[SLOT_W-1:0]];
      else if ((idxReg == IDX_W'(12) || idxReg == IDX_W'(13)) && VARIANT == VAR_A)
        rdVal = regs[idxReg[SLOT_W-1:0]];
      else if (idxReg == IDX_PEN_HI)
        rdVal = DATA_W'(penAddr[PEN_W-1:DATA_W]);
      else if (idxReg == IDX_PEN_LO)
        rdVal = penAddr[DATA_W-1:0];
      else if (idxReg == IDX_LAST && VARIANT == VAR_B)
        rdVal = '1;
    end
  end

  assign readData = rdVal;
  assign regOut   = regs;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrIndex |=> idxReg == $past(dataIn[IDX_W-1:0])); // R2
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> $stable(regs)); // R1
  AST_HIGH_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && !idxInFile) |=> $stable(regs)); // R4

endmodule

// File: rtl/vidregs_top.sv
module vidregs_top
  import vidregs_pkg::*;
#(
  parameter variant_e VARIANT = VAR_A,
  parameter int       ADDR_W  = 16,
  parameter int       DATA_W  = 8,
  parameter int       IDX_W   = 5,
  parameter int       NUM_RW  = 16,
  parameter int       PEN_W   = 14
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ioStrobe,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             dataIn,
  input  logic                          penStrobe,
  input  logic [PEN_W-1:0]              penAddr,
  input  logic                          vertPastDisplay,
  input  logic                          frameStart,
  output logic [DATA_W-1:0]             readData,
  output logic [NUM_RW-1:0][DATA_W-1:0] regOut
);

  busStrobe_t strb;

  vidregs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .addr(addr), .strb(strb)
  );

  vidregs_datapath #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_RW(NUM_RW), .PEN_W(PEN_W), .VARIANT(VARIANT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .penStrobe(penStrobe), .penAddr(penAddr),
    .vertPastDisplay(vertPastDisplay), .frameStart(frameStart),
    .readData(readData), .regOut(regOut)
  );

endmodule

// File: tb/vidregs_top_bench.sv
`timescale 1ns/1ps
module vidregs_top_bench;
  import vidregs_pkg::*;

  localparam logic [15:0] P_IDX  = 16'hBC00;
  localparam logic [15:0] P_WR   = 16'hBD00;
  localparam logic [15:0] P_STAT = 16'hBE00;
  localparam logic [15:0] P_RD   = 16'hBF00;
  localparam logic [15:0] P_OFF  = 16'hFC00;

  // {index, written, expected regOut, expected read A, expected read B}
  localparam int NV = 11;
  localparam logic [39:0] VECS [0:NV-1] = '{
    {8'd0,  8'h3F, 8'h3F, 8'h00, 8'h00},
    {8'd3,  8'h8E, 8'h8E, 8'h00, 8'h00},
    {8'd4,  8'hFF, 8'h7F, 8'h00, 8'h00},
    {8'd5,  8'hFF, 8'h1F, 8'h00, 8'h00},
    {8'd6,  8'h99, 8'h19, 8'h00, 8'h00},
    {8'd7,  8'h9E, 8'h1E, 8'h00, 8'h00},
    {8'd9,  8'hE7, 8'h07, 8'h00, 8'h00},
    {8'd12, 8'hF0, 8'h30, 8'h30, 8'h00},
    {8'd13, 8'hA5, 8'hA5, 8'hA5, 8'h00},
    {8'd14, 8'hFF, 8'h3F, 8'h3F, 8'h3F},
    {8'd15, 8'h5A, 8'h5A, 8'h5A, 8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioStrobe = 1'b0;
  logic [15:0] addr = P_OFF;
  logic [7:0] dataIn = '0;
  logic penStrobe = 1'b0;
  logic [13:0] penAddr = 14'h2A5C;
  logic vertPastDisplay = 1'b0;
  logic frameStart = 1'b0;
  logic [7:0] rdA, rdB;
  logic [15:0][7:0] outA, outB;
  logic [7:0] lastA, lastB;
  logic [15:0][7:0] snapA;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vidregs_top #(.VARIANT(VAR_B)) u_vidregs_top (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .addr(addr), .dataIn(dataIn),
    .penStrobe(penStrobe), .penAddr(penAddr), .vertPastDisplay(vertPastDisplay),
    .frameStart(frameStart), .readData(rdB), .regOut(outB)
  );

  vidregs_top #(.VARIANT(VAR_A)) u_vidregs_top_a (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .addr(addr), .dataIn(dataIn),
    .penStrobe(penStrobe), .penAddr(penAddr), .vertPastDisplay(vertPastDisplay),
    .frameStart(frameStart), .readData(rdA), .regOut(outA)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic busOp(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ioStrobe = 1'b1;
    #1;
    lastA = rdA; lastB = rdB;
    @(negedge clk);
    ioStrobe = 1'b0; addr = P_OFF;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) penStrobe = 1'b1;
    else if (which == 1) vertPastDisplay = 1'b1;
    else frameStart = 1'b1;
    @(negedge clk);
    penStrobe = 1'b0; vertPastDisplay = 1'b0; frameStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    for (int i = 0; i < 16; i++) check("R12 regOut A", outA[i], 8'h00);
    busOp(P_STAT, 8'h00);
    check("R12 status B", lastB, 8'h00);
    busOp(P_WR, 8'h11);                       // index reset to 0
    check("R12 index B", outB[0], 8'h11);
    check("R12 index A", outA[0], 8'h11);

    // R1: deselected accesses ignored
    busOp(P_OFF, 8'h05);
    busOp(P_OFF | 16'h0100, 8'h77);
    check("R1 reg0 kept", outA[0], 8'h11);
    check("R1 reg5 kept", outB[5], 8'h00);

    // R2/R3/R5/R6: table of write then read
    for (int v = 0; v < NV; v++) begin
      busOp(P_IDX, VECS[v][39:32]);
      busOp(P_WR, VECS[v][31:24]);
      check("R3 regOut A", outA[VECS[v][35:32]], VECS[v][23:16]);
      check("R3 regOut B", outB[VECS[v][35:32]], VECS[v][23:16]);
      busOp(P_RD, 8'h00);
      check("R5 R6 read A", lastA, VECS[v][15:8]);
      check("R5 R6 read B", lastB, VECS[v][7:0]);
    end

    // R2: index port stores only bits 4..0 (0xE4 -> index 4)
    busOp(P_IDX, 8'hE4);
    busOp(P_WR, 8'h21);
    check("R2 index low bits", outA[4], 8'h21);

    // R4 / R7: write to 16 ignored, pen address readback
    snapA = outA;
    busOp(P_IDX, 8'd16);
    busOp(P_WR, 8'hFF);
    busOp(P_RD, 8'h00);
    check("R7 idx16 A", lastA, 8'h2A);
    check("R7 idx16 B", lastB, 8'h2A);
    check("R4 no store", (outA == snapA) ? 8'h01 : 8'h00, 8'h01);
    busOp(P_IDX, 8'd17);
    busOp(P_RD, 8'h00);
    check("R7 idx17 B", lastB, 8'h5C);

    // R8 / R4: unimplemented indices
    busOp(P_IDX, 8'd20);
    busOp(P_RD, 8'h00);
    check("R8 idx20 A", lastA, 8'h00);
    check("R8 idx20 B", lastB, 8'h00);
    busOp(P_IDX, 8'd31);
    busOp(P_WR, 8'h00);
    busOp(P_RD, 8'h00);
    check("R8 idx31 A", lastA, 8'h00);
    check("R8 R4 idx31 B", lastB, 8'hFF);

    // R9: pen flag
    pulse(0);
    busOp(P_STAT, 8'h00);
    check("R9 pen set B", lastB, 8'h40);
    check("R11 status A", lastA, 8'h00);
    busOp(P_IDX, 8'd16);
    busOp(P_RD, 8'h00);
    busOp(P_STAT, 8'h00);
    check("R9 pen cleared B", lastB, 8'h00);

    // R10: vertical flag, set wins over frame start
    pulse(1);
    busOp(P_STAT, 8'h00);
    check("R10 vb set B", lastB, 8'h20);
    busOp(P_STAT, 8'h00);
    check("R10 vb held B", lastB, 8'h20);
    pulse(2);
    busOp(P_STAT, 8'h00);
    check("R10 vb cleared B", lastB, 8'h00);
    @(negedge clk);
    vertPastDisplay = 1'b1; frameStart = 1'b1;
    @(negedge clk);
    vertPastDisplay = 1'b0; frameStart = 1'b0;
    busOp(P_STAT, 8'h00);
    check("R10 set wins B", lastB, 8'h20);

    // R11: no read output without a selected read access
    busOp(P_IDX, 8'd15);
    @(negedge clk);
    addr = P_RD; #1;
    check("R11 idle A", rdA, 8'h00);
    check("R11 idle B", rdB, 8'h00);
    busOp(P_RD & 16'hFFFF | 16'h4000, 8'h00);
    check("R11 deselected read B", lastB, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule